// File: doc/BRIEF.md
# Four-Mode Split/Joined Timer

This block is a counter built from two equal halves, a low half and a high half, whose arrangement is picked by a 2-bit mode field in a control word. The two halves can form one wide counter. They can run as two separate timers, in which case the high half is slowed by its own small prescaler. In chained mode the low half acts as a divider that paces the high half. The fourth mode is a wide watchdog arrangement. Here it counts exactly like the wide counter, and the only watchdog behaviour modelled is an input that locks the half-reset bits.

Each half has an active-low run gate bit in the control word. Clearing the bit stops that half and drops its status, but the count is kept. A per-half enable input picks off, one-shot or continuous counting against that half's period word. A period match raises the half's status output for one timer clock. The output enable of the timer pin follows the low half's gate bit. All counting happens only on clock cycles where the timer clock enable is high.

Software-side access is a plain write port and a combinational read port. Select 0 is the control word, 1 and 2 are the low and high period words, and 3 and 4 read back the low and high counts.

Top module: `tmr_dual`

## Requirements
- R1: After reset the control word, both period words and both counts read 0, both status outputs are 0 and `out_en` is 0.
- R2: Control word layout: bit 0 is the low gate, bit 1 is the high gate, bits 3:2 are the mode (00 wide, 01 split, 10 watchdog, 11 chained), bits 11:8 are the high prescale period and bits 15:12 are the high prescale count (a write loads it). Bits 31:16 and 7:4 always read 0 whatever is written.
- R3: In modes 00 and 10 the halves form one counter that advances when both gates are 1, `lo_run` is not off and `tick_en` is high. The high half steps when the low half wraps from all ones. It is compared with {high period, low period}, and a match pulses `lo_stat`.
- R4: Enable encoding is 00 off, 01 one-shot, 1x continuous. On a match, continuous clears the counter on that tick. One-shot holds the counter at the period with a single status pulse, until the enable returns to off.
- R5: In mode 01 the low half counts against the low period under `lo_run`, independently of the high half.
- R6: In mode 01 the high prescale count advances on each enabled tick and returns to 0 when it equals the prescale period. The high counter steps on the enabled tick after such a match, so with a prescale period of P the count rises once per P+1 ticks.
- R7: In mode 11, enabled by `hi_run` and both gates, the low half counts to its period and then returns to 0. That same tick steps the high half, which counts against the high period and pulses `hi_stat` on a match.
- R8: While a half's gate bit is 0, its count does not change and its status output is 0 from the next clock on.
- R9: `out_en` equals the low gate bit.
- R10: While `wdog_active` is 1, control writes leave both gate bits unchanged; the other fields are still written.
- R11: With `tick_en` low no count changes.
- R12: A status output is high for one timer clock per match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Timer clock enable |
| wdog_active | input | 1 | Locks both gate bits against writes |
| lo_run | input | 2 | Low half enable: 00 off, 01 one-shot, 1x continuous |
| hi_run | input | 2 | High half enable, same encoding |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 3 | Write target: 0 control, 1 low period, 2 high period |
| wr_data | input | 32 | Write data |
| rd_sel | input | 3 | Read target: 0 control, 1/2 periods, 3/4 counts |
| rd_data | output | 32 | Read data, zero-extended |
| lo_stat | output | 1 | Low (or wide) match pulse |
| hi_stat | output | 1 | High half match pulse |
| out_en | output | 1 | Timer output enable |

## Verification
The checker watches several rules on every cycle. Counts freeze while `tick_en` is low. A half with a cleared gate bit keeps its count, and the low status is dropped. Gate bits stay fixed while the watchdog input is high. The high half moves in chained mode only when the low half is at its period, and the reserved control bits read zero. Wide-mode carry, the one-clock lag of the split-mode prescaler, one-shot hold and release, and the status pulse width depend on long count sequences. Those are shown only by the bench scenarios, which compare every cycle against a reference model and against literal counts at chosen points.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
   localparam int DW = 32;

   typedef enum logic [1:0] {
      MODE_WIDE  = 2'b00,
      MODE_SPLIT = 2'b01,
      MODE_WDOG  = 2'b10,
      MODE_CHAIN = 2'b11
   } tmr_mode_e;

   localparam logic [2:0] SEL_CTRL   = 3'd0;
   localparam logic [2:0] SEL_PRD_LO = 3'd1;
   localparam logic [2:0] SEL_PRD_HI = 3'd2;
   localparam logic [2:0] SEL_CNT_LO = 3'd3;
   localparam logic [2:0] SEL_CNT_HI = 3'd4;

   localparam int GATE_LO_BIT = 0;
   localparam int GATE_HI_BIT = 1;
   localparam int MODE_LSB    = 2;
   localparam int PPRD_LSB    = 8;
   localparam int PCNT_LSB    = 12;
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
   import tmr_pkg::*;
#(
   parameter int CW = 32,
   parameter int PW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [2:0]    wr_sel,
   input  logic [DW-1:0] wr_data,
   input  logic          wdog_active,
   output logic          rs_lo,
   output logic          rs_hi,
   output tmr_mode_e     mode,
   output logic [PW-1:0] psc_prd,
   output logic          psc_ld,
   output logic [PW-1:0] psc_ld_val,
   output logic [CW-1:0] prd_lo,
   output logic [CW-1:0] prd_hi
);
   logic ctrl_wr;
   logic unused_wr;

   assign ctrl_wr    = wr_en && (wr_sel == SEL_CTRL);
   assign psc_ld     = ctrl_wr;
   assign psc_ld_val = wr_data[PCNT_LSB +: PW];
   assign unused_wr  = ^wr_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rs_lo   <= 1'b0;
         rs_hi   <= 1'b0;
         mode    <= MODE_WIDE;
         psc_prd <= '0;
         prd_lo  <= '0;
         prd_hi  <= '0;
      end else if (wr_en) begin
         if (wr_sel == SEL_CTRL) begin
            mode    <= tmr_mode_e'(wr_data[MODE_LSB +: 2]);
            psc_prd <= wr_data[PPRD_LSB +: PW];
            if (!wdog_active) begin
               rs_lo <= wr_data[GATE_LO_BIT];
               rs_hi <= wr_data[GATE_HI_BIT];
            end
         end
         if (wr_sel == SEL_PRD_LO) prd_lo <= wr_data[CW-1:0];
         if (wr_sel == SEL_PRD_HI) prd_hi <= wr_data[CW-1:0];
      end
   end
endmodule

// File: rtl/tmr_psc.sv
module tmr_psc #(
   parameter int PW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          ld,
   input  logic [PW-1:0] ld_val,
   input  logic          run,
   input  logic          split,
   input  logic [PW-1:0] prd,
   output logic [PW-1:0] cnt,
   output logic          pend
);
   logic hit;
   assign hit = (cnt == prd);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt  <= '0;
         pend <= 1'b0;
      end else begin
         if (ld)       cnt <= ld_val;
         else if (run) cnt <= hit ? '0 : cnt + PW'(1);
         if (!split)   pend <= 1'b0;
         else if (run) pend <= hit;
      end
   end
endmodule

// File: rtl/tmr_half.sv
module tmr_half #(
   parameter int CW = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          inc,
   input  logic          clr,
   output logic [CW-1:0] cnt
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt <= '0;
      else if (clr) cnt <= '0;
      else if (inc) cnt <= cnt + CW'(1);
   end
endmodule

// File: rtl/tmr_dual.sv
module tmr_dual
   import tmr_pkg::*;
#(
   parameter int CW = 32,
   parameter int PW = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick_en,
   input  logic          wdog_active,
   input  logic [1:0]    lo_run,
   input  logic [1:0]    hi_run,
   input  logic          wr_en,
   input  logic [2:0]    wr_sel,
   input  logic [31:0]   wr_data,
   input  logic [2:0]    rd_sel,
   output logic [31:0]   rd_data,
   output logic          lo_stat,
   output logic          hi_stat,
   output logic          out_en
);
   localparam int NH  = 2;
   localparam int PAD = 4 - PW;

   if (CW < 2 || CW > DW) begin : g_bad_cw
      $error("tmr_dual: CW must lie in 2..32");
   end
   if (PW < 1 || PW > 4) begin : g_bad_pw
      $error("tmr_dual: PW must lie in 1..4");
   end

   logic            rs_lo, rs_hi;
   tmr_mode_e       mode;
   logic [PW-1:0]   psc_prd, psc_ld_val, psc_cnt;
   logic            psc_ld, psc_pend, psc_run;
   logic [CW-1:0]   prd_lo, prd_hi;
   logic [CW-1:0]   cnt_q [NH];
   logic [CW-1:0]   cnt_lo, cnt_hi;
   logic [NH-1:0]   inc_v, clr_v;
   logic            set_lo, set_hi, fin_lo, fin_hi;
   logic            done_lo, done_hi;
   logic            lo_stat_q, hi_stat_q;
   logic            lo_on, hi_on, lo_hit, hi_hit, wide_hit;

   tmr_regs #(.CW(CW), .PW(PW)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .wdog_active(wdog_active),
      .rs_lo(rs_lo), .rs_hi(rs_hi), .mode(mode), .psc_prd(psc_prd),
      .psc_ld(psc_ld), .psc_ld_val(psc_ld_val),
      .prd_lo(prd_lo), .prd_hi(prd_hi)
   );

   tmr_psc #(.PW(PW)) u_psc (
      .clk(clk), .rst_n(rst_n), .ld(psc_ld), .ld_val(psc_ld_val),
      .run(psc_run), .split(mode == MODE_SPLIT), .prd(psc_prd),
      .cnt(psc_cnt), .pend(psc_pend)
   );

   for (genvar h = 0; h < NH; h++) begin : g_half
      tmr_half #(.CW(CW)) u_half (
         .clk(clk), .rst_n(rst_n), .inc(inc_v[h]), .clr(clr_v[h]),
         .cnt(cnt_q[h])
      );
   end

   assign cnt_lo   = cnt_q[0];
   assign cnt_hi   = cnt_q[1];
   assign lo_on    = (lo_run != 2'b00);
   assign hi_on    = (hi_run != 2'b00);
   assign lo_hit   = (cnt_lo == prd_lo);
   assign hi_hit   = (cnt_hi == prd_hi);
   assign wide_hit = ({cnt_hi, cnt_lo} == {prd_hi, prd_lo});

   always_comb begin
      inc_v   = '0;
      clr_v   = '0;
      set_lo  = 1'b0;
      set_hi  = 1'b0;
      fin_lo  = 1'b0;
      fin_hi  = 1'b0;
      psc_run = 1'b0;
      case (mode)
         MODE_SPLIT: begin
            if (tick_en && rs_lo && lo_on && !done_lo) begin
               if (lo_hit) begin
                  set_lo = 1'b1;
                  if (lo_run[1]) clr_v[0] = 1'b1;
                  else           fin_lo   = 1'b1;
               end else begin
                  inc_v[0] = 1'b1;
               end
            end
            psc_run = tick_en && rs_hi && hi_on && !done_hi;
            if (psc_run && psc_pend) begin
               if (hi_hit) begin
                  set_hi = 1'b1;
                  if (hi_run[1]) clr_v[1] = 1'b1;
                  else           fin_hi   = 1'b1;
               end else begin
                  inc_v[1] = 1'b1;
               end
            end
         end
         MODE_CHAIN: begin
            if (tick_en && rs_lo && rs_hi && hi_on && !done_hi) begin
               if (lo_hit) begin
                  clr_v[0] = 1'b1;
                  if (hi_hit) begin
                     set_hi = 1'b1;
                     if (hi_run[1]) clr_v[1] = 1'b1;
                     else           fin_hi   = 1'b1;
                  end else begin
                     inc_v[1] = 1'b1;
                  end
               end else begin
                  inc_v[0] = 1'b1;
               end
            end
         end
         default: begin
            if (tick_en && rs_lo && rs_hi && lo_on && !done_lo) begin
               if (wide_hit) begin
                  set_lo = 1'b1;
                  if (lo_run[1]) clr_v = '1;
                  else           fin_lo = 1'b1;
               end else begin
                  inc_v[0] = 1'b1;
                  inc_v[1] = &cnt_lo;
               end
            end
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_lo   <= 1'b0;
         done_hi   <= 1'b0;
         lo_stat_q <= 1'b0;
         hi_stat_q <= 1'b0;
      end else begin
         done_lo   <= !lo_on ? 1'b0 : (fin_lo | done_lo);
         done_hi   <= !hi_on ? 1'b0 : (fin_hi | done_hi);
         lo_stat_q <= !rs_lo ? 1'b0 : (tick_en ? set_lo : lo_stat_q);
         hi_stat_q <= !rs_hi ? 1'b0 : (tick_en ? set_hi : hi_stat_q);
      end
   end

   always_comb begin
      rd_data = '0;
      case (rd_sel)
         SEL_CTRL: begin
            rd_data[PCNT_LSB +: 4]  = {{PAD{1'b0}}, psc_cnt};
            rd_data[PPRD_LSB +: 4]  = {{PAD{1'b0}}, psc_prd};
            rd_data[MODE_LSB +: 2]  = mode;
            rd_data[GATE_HI_BIT]    = rs_hi;
            rd_data[GATE_LO_BIT]    = rs_lo;
         end
         SEL_PRD_LO: rd_data[CW-1:0] = prd_lo;
         SEL_PRD_HI: rd_data[CW-1:0] = prd_hi;
         SEL_CNT_LO: rd_data[CW-1:0] = cnt_lo;
         SEL_CNT_HI: rd_data[CW-1:0] = cnt_hi;
         default:    rd_data = '0;
      endcase
   end

   assign lo_stat = lo_stat_q;
   assign hi_stat = hi_stat_q;
   assign out_en  = rs_lo;
endmodule

// File: rtl/tmr_dual_chk.sv
module tmr_dual_chk #(
   parameter int CW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          tick_en,
   input logic          wdog_active,
   input logic          rs_lo,
   input logic          rs_hi,
   input logic [1:0]    mode,
   input logic [CW-1:0] cnt_lo,
   input logic [CW-1:0] cnt_hi,
   input logic [CW-1:0] prd_lo,
   input logic          lo_stat,
   input logic [2:0]    rd_sel,
   input logic [31:0]   rd_data
);
   AST_IDLE_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_en |=> ($stable(cnt_lo) && $stable(cnt_hi))); // R11
   AST_GATE_HOLDS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      !rs_lo |=> $stable(cnt_lo)); // R8
   AST_GATE_DROPS_STAT: assert property (@(posedge clk) disable iff (!rst_n)
      !rs_lo |=> !lo_stat); // R8
   AST_GATE_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
      wdog_active |=> ($stable(rs_lo) && $stable(rs_hi))); // R10
   AST_CHAIN_PACE: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b11 && cnt_lo != prd_lo) |=> $stable(cnt_hi)); // R7
   AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_sel == 3'd0) |-> (rd_data[31:16] == 16'h0 && rd_data[7:4] == 4'h0)); // R2
endmodule

bind tmr_dual tmr_dual_chk #(.CW(CW)) u_chk (
   .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wdog_active(wdog_active),
   .rs_lo(rs_lo), .rs_hi(rs_hi), .mode(mode), .cnt_lo(cnt_lo),
   .cnt_hi(cnt_hi), .prd_lo(prd_lo), .lo_stat(lo_stat),
   .rd_sel(rd_sel), .rd_data(rd_data)
);

// File: tb/tmr_dual_bench.sv
module tmr_dual_bench;
   localparam int CW = 8;
   localparam int PW = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b0, wdog_active = 1'b0, wr_en = 1'b0;
   logic [1:0]  lo_run = 2'b00, hi_run = 2'b00;
   logic [2:0]  wr_sel = 3'd0, rd_sel = 3'd0;
   logic [31:0] wr_data = 32'h0;
   logic [31:0] rd_data;
   logic        lo_stat, hi_stat, out_en;

   int total = 0, bad = 0;
   bit ended = 1'b0;

   always #2.5 clk = ~clk;

   tmr_dual #(.CW(CW), .PW(PW)) u_tmr_dual (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wdog_active(wdog_active),
      .lo_run(lo_run), .hi_run(hi_run), .wr_en(wr_en), .wr_sel(wr_sel),
      .wr_data(wr_data), .rd_sel(rd_sel), .rd_data(rd_data),
      .lo_stat(lo_stat), .hi_stat(hi_stat), .out_en(out_en)
   );

   // reference state
   logic       m_rl = 0, m_rh = 0, m_pend = 0, m_dl = 0, m_dh = 0, m_sl = 0, m_sh = 0;
   logic [1:0] m_mode = 0;
   logic [3:0] m_pp = 0, m_psc = 0;
   logic [7:0] m_pl = 0, m_ph = 0, m_cl = 0, m_ch = 0;

   task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s act=%0h exp=%0h", rq, act, exp);
      end
   endtask

   function automatic logic [31:0] m_rd(input logic [2:0] s);
      case (s)
         3'd0: return {16'h0, m_psc, m_pp, 4'h0, m_mode, m_rh, m_rl};
         3'd1: return {24'h0, m_pl};
         3'd2: return {24'h0, m_ph};
         3'd3: return {24'h0, m_cl};
         3'd4: return {24'h0, m_ch};
         default: return 32'h0;
      endcase
   endfunction

   function automatic string mode_tag(input logic [1:0] md);
      case (md)
         2'b01: return "R5";
         2'b11: return "R7";
         default: return "R3";
      endcase
   endfunction

   task automatic model_step();
      logic [7:0] ncl, nch;
      logic [3:0] npsc;
      logic npend, ndl, ndh, sl, sh, prun;
      ncl = m_cl; nch = m_ch; npsc = m_psc; ndl = m_dl; ndh = m_dh;
      sl = 0; sh = 0; prun = 0;
      case (m_mode)
         2'b01: begin
            if (tick_en && m_rl && lo_run != 0 && !m_dl) begin
               if (m_cl == m_pl) begin sl = 1; if (lo_run[1]) ncl = 0; else ndl = 1; end
               else ncl = m_cl + 1;
            end
            prun = tick_en && m_rh && hi_run != 0 && !m_dh;
            if (prun && m_pend) begin
               if (m_ch == m_ph) begin sh = 1; if (hi_run[1]) nch = 0; else ndh = 1; end
               else nch = m_ch + 1;
            end
         end
         2'b11: begin
            if (tick_en && m_rl && m_rh && hi_run != 0 && !m_dh) begin
               if (m_cl == m_pl) begin
                  ncl = 0;
                  if (m_ch == m_ph) begin sh = 1; if (hi_run[1]) nch = 0; else ndh = 1; end
                  else nch = m_ch + 1;
               end else ncl = m_cl + 1;
            end
         end
         default: begin
            if (tick_en && m_rl && m_rh && lo_run != 0 && !m_dl) begin
               if ({m_ch, m_cl} == {m_ph, m_pl}) begin
                  sl = 1;
                  if (lo_run[1]) begin ncl = 0; nch = 0; end else ndl = 1;
               end else begin
                  ncl = m_cl + 1;
                  if (m_cl == 8'hFF) nch = m_ch + 1;
               end
            end
         end
      endcase
      if (lo_run == 0) ndl = 0;
      if (hi_run == 0) ndh = 0;
      npend = (m_mode != 2'b01) ? 1'b0 : (prun ? (m_psc == m_pp) : m_pend);
      if (wr_en && wr_sel == 3'd0) npsc = wr_data[15:12];
      else if (prun) npsc = (m_psc == m_pp) ? 4'h0 : m_psc + 4'h1;
      m_sl <= !m_rl ? 1'b0 : (tick_en ? sl : m_sl);
      m_sh <= !m_rh ? 1'b0 : (tick_en ? sh : m_sh);
      m_cl <= ncl; m_ch <= nch; m_psc <= npsc; m_pend <= npend;
      m_dl <= ndl; m_dh <= ndh;
      if (wr_en) begin
         if (wr_sel == 3'd0) begin
            m_mode <= wr_data[3:2];
            m_pp   <= wr_data[11:8];
            if (!wdog_active) begin m_rl <= wr_data[0]; m_rh <= wr_data[1]; end
         end
         if (wr_sel == 3'd1) m_pl <= wr_data[7:0];
         if (wr_sel == 3'd2) m_ph <= wr_data[7:0];
      end
   endtask

   // one clock: model follows the edge, outputs compared at the falling edge
   task automatic cyc();
      @(posedge clk);
      if (rst_n) model_step();
      @(negedge clk);
      chk("R12 lo_stat", {31'h0, lo_stat}, {31'h0, m_sl});
      chk("R12 hi_stat", {31'h0, hi_stat}, {31'h0, m_sh});
      chk("R9 out_en", {31'h0, out_en}, {31'h0, m_rl});
      chk(rd_sel == 3'd0 ? "R2 ctrl" : mode_tag(m_mode), rd_data, m_rd(rd_sel));
   endtask

   task automatic ticks(input int n);
      tick_en = 1'b1;
      repeat (n) cyc();
      tick_en = 1'b0;
   endtask

   task automatic wr(input logic [2:0] s, input logic [31:0] d);
      wr_en = 1'b1; wr_sel = s; wr_data = d;
      cyc();
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] s, output logic [31:0] v);
      rd_sel = s;
      #1;
      v = rd_data;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!ended) begin
         ended = 1'b1;
         total++; bad++;
         $display("FAIL watchdog act=hung exp=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] v;
      void'($urandom(32'd4242));
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      for (int s = 0; s < 5; s++) begin
         rd(3'(s), v);
         chk("R1 reset read", v, 32'h0);
      end
      chk("R1 stat", {30'h0, lo_stat, hi_stat}, 32'h0);
      chk("R1 out_en", {31'h0, out_en}, 32'h0);
      cyc();

      // R2 reserved bits
      wr(3'd0, 32'hFFFF_FFFF);
      rd(3'd0, v);
      chk("R2 ctrl all ones", v, 32'h0000_FF0F);
      chk("R9 out_en set", {31'h0, out_en}, 32'h1);
      wr(3'd0, 32'h0);
      chk("R9 out_en clear", {31'h0, out_en}, 32'h0);

      // R3 wide counter with carry, continuous
      wr(3'd1, 32'd3);
      wr(3'd2, 32'd1);
      wr(3'd0, 32'h3);
      lo_run = 2'b10;
      ticks(259);
      rd(3'd4, v); chk("R3 carry high", v, 32'd1);
      rd(3'd3, v); chk("R3 low", v, 32'd3);
      chk("R3 no stat yet", {31'h0, lo_stat}, 32'h0);
      ticks(1);
      chk("R3 wide match stat", {31'h0, lo_stat}, 32'h1);
      rd(3'd3, v); chk("R4 continuous clear", v, 32'd0);
      ticks(1);
      chk("R12 pulse ends", {31'h0, lo_stat}, 32'h0);
      rd(3'd3, v); chk("R3 restart", v, 32'd1);
      lo_run = 2'b00;

      // R7 chained
      wr(3'd1, 32'd2);
      wr(3'd2, 32'd10);
      wr(3'd0, 32'hF);
      hi_run = 2'b10;
      ticks(2);
      rd(3'd4, v); chk("R7 first step", v, 32'd1);
      ticks(9);
      rd(3'd4, v); chk("R7 high after 11", v, 32'd4);
      rd(3'd3, v); chk("R7 low wrapped", v, 32'd0);
      hi_run = 2'b00;

      // R4 one-shot in split mode, R5 low half alone
      wr(3'd1, 32'd4);
      wr(3'd0, 32'h7);
      lo_run = 2'b01;
      ticks(4);
      rd(3'd3, v); chk("R5 low counts", v, 32'd4);
      ticks(1);
      chk("R4 one-shot stat", {31'h0, lo_stat}, 32'h1);
      ticks(6);
      rd(3'd3, v); chk("R4 one-shot hold", v, 32'd4);
      chk("R4 single pulse", {31'h0, lo_stat}, 32'h0);
      rd(3'd4, v); chk("R5 high untouched", v, 32'd4);
      lo_run = 2'b00;

      // R6 high prescaler
      wr(3'd2, 32'd200);
      wr(3'd0, 32'h0207);
      hi_run = 2'b10;
      ticks(3);
      rd(3'd4, v); chk("R6 no step yet", v, 32'd4);
      ticks(1);
      rd(3'd4, v); chk("R6 step after lag", v, 32'd5);
      ticks(3);
      rd(3'd4, v); chk("R6 period of three", v, 32'd6);

      // R8 high gate cleared
      wr(3'd0, 32'h0205);
      ticks(10);
      rd(3'd4, v); chk("R8 count held", v, 32'd6);
      chk("R8 stat low", {31'h0, hi_stat}, 32'h0);
      hi_run = 2'b00;

      // R10 watchdog lock
      wdog_active = 1'b1;
      wr(3'd0, 32'h0);
      rd(3'd0, v); chk("R10 gates locked", v & 32'h3, 32'h1);
      wdog_active = 1'b0;

      // R11 idle tick enable, then live continuous clear
      wr(3'd0, 32'h7);
      lo_run = 2'b10;
      repeat (10) cyc();
      rd(3'd3, v); chk("R11 frozen", v, 32'd4);
      ticks(1);
      rd(3'd3, v); chk("R4 continuous wrap", v, 32'd0);

      // random phase against the reference model
      for (int i = 0; i < 4000; i++) begin
         tick_en     = ($urandom % 4) != 0;
         wdog_active = ($urandom % 8) == 0;
         rd_sel      = 3'($urandom % 5);
         if (($urandom % 32) == 0) lo_run = 2'($urandom);
         if (($urandom % 32) == 0) hi_run = 2'($urandom);
         if (($urandom % 16) == 0) begin
            wr_en   = 1'b1;
            wr_sel  = 3'($urandom % 3);
            wr_data = (wr_sel == 3'd0) ? ($urandom | 32'h3) : ($urandom & 32'h7);
         end else begin
            wr_en = 1'b0;
         end
         cyc();
      end
      wr_en = 1'b0;

      ended = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule